// File: doc/BRIEF.md
# CRTC Sync Timing Generator

This block produces the raster timing for a display: a pixel counter, a line counter, horizontal and vertical sync pulses and a display-enable strobe. Everything runs in the pixel clock domain. A host programs the raster through a small write-only register port. The line length and the active width are given in 8-pixel character units. The hsync start is a plain pixel position. All vertical quantities are in lines. Totals and active extents are stored minus one.

Timing writes go first into a shadow copy. That copy moves into the working set only on the clock edge where the last pixel of the last line wraps to pixel 0 of line 0, so a frame is never drawn with mixed timing. A separate blanking register acts on the very next cycle. It can force display-enable low and hold either sync at its inactive level.

Top module: `crtc_timing_gen`

## Requirements
- R1: After a synchronous reset, pix_x and line_y are 0 and blanking is cleared. The working timing is then: line of 32 pixels, 16 active pixels, hsync from pixel 20 for 8 pixels, 10 lines, 6 active lines, vsync on line 7 only, both polarities active high.
- R2: pix_x counts up by one on every clock from 0 to 8*(T+1)-1 and then returns to 0. T sits in bits 9:0 of the word at address 0. line_y increments on each such wrap.
- R3: line_y counts from 0 to V and returns to 0 together with pix_x, which starts a new frame. V sits in bits 15:0 of the word at address 2.
- R4: de is high exactly when pix_x < 8*(A+1) and line_y <= L. A is bits 24:16 of the word at address 0. L is bits 27:16 of the word at address 2.
- R5: The hsync pulse covers pix_x from S up to, but not including, S+8*W. S is bits 12:0 and W is bits 21:16 of the word at address 1.
- R6: The vsync pulse covers line_y from P+1 up to, but not including, P+1+N. P is bits 11:0 and N is bits 20:16 of the word at address 3.
- R7: A sync width field of 0 acts as a width of 1: 8 pixels for hsync and 1 line for vsync.
- R8: Bit 23 of address 1 (horizontal) or address 3 (vertical) set to 1 makes that sync active low. Its idle level is then high.
- R9: Writes to addresses 0 to 3 leave the frame in progress unchanged. They take effect from the first pixel of the following frame.
- R10: The word at address 4 controls blanking. Bit 0 forces de low, bit 1 holds hsync at its idle level, and bit 2 holds vsync at its idle level. Each bit acts from the cycle after the write, and clearing it restores normal output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address (0 to 4) |
| wr_data | input | 32 | Register write data |
| pix_x | output | 13 | Pixel position within the line |
| line_y | output | 16 | Line position within the frame |
| de | output | 1 | Display enable |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |

## Verification
The coordinates come from registers. de, hsync and vsync are decoded combinationally from those registers, so all five outputs describe the same pixel in the same cycle.

A blanking write shows at the first falling edge after the rising edge that captured it. A timing write shows only from the cycle in which both counters read zero after the next frame wrap. The bench drives on falling edges and samples only there. It waits for the coordinate pair (0,0) before comparing a whole frame against its own model, pixel by pixel, and it skips one extra cycle after each timing write so that a write landing on the wrap edge cannot shift which frame is compared.

// File: rtl/crtc_pkg.sv
package crtc_pkg;

    // register field widths
    localparam int HT_W    = 10;
    localparam int HD_W    = 9;
    localparam int HSS_W   = 13;
    localparam int HSW_W   = 6;
    localparam int VT_W    = 16;
    localparam int VD_W    = 12;
    localparam int VSS_W   = 12;
    localparam int VSW_W   = 5;
    localparam int REG_W   = 32;
    localparam int ADDR_W  = 3;
    localparam int UPPER_LSB = 16;
    localparam int POL_BIT   = 23;

    // derived counter widths: one character is 8 pixels
    localparam int CHAR_SH = 3;
    localparam int X_W     = HT_W + CHAR_SH;
    localparam int Y_W     = VT_W;

    typedef enum logic [ADDR_W-1:0] {
        ADR_HTIME = 3'd0,
        ADR_HSYNC = 3'd1,
        ADR_VTIME = 3'd2,
        ADR_VSYNC = 3'd3,
        ADR_BLANK = 3'd4
    } crtc_addr_e;

    typedef struct packed {
        logic [HT_W-1:0]  h_total_m1;
        logic [HD_W-1:0]  h_disp_m1;
        logic [HSS_W-1:0] hs_start;
        logic [HSW_W-1:0] hs_wid;
        logic             hs_low;
        logic [VT_W-1:0]  v_total_m1;
        logic [VD_W-1:0]  v_disp_m1;
        logic [VSS_W-1:0] vs_start_m1;
        logic [VSW_W-1:0] vs_wid;
        logic             vs_low;
    } crtc_timing_t;

    typedef struct packed {
        logic kill_de;
        logic kill_hs;
        logic kill_vs;
    } crtc_blank_t;

    localparam crtc_timing_t TIMING_RST = '{
        h_total_m1:  HT_W'(3),
        h_disp_m1:   HD_W'(1),
        hs_start:    HSS_W'(20),
        hs_wid:      HSW_W'(1),
        hs_low:      1'b0,
        v_total_m1:  VT_W'(9),
        v_disp_m1:   VD_W'(5),
        vs_start_m1: VSS_W'(6),
        vs_wid:      VSW_W'(1),
        vs_low:      1'b0
    };

    function automatic logic [HSW_W-1:0] h_width_eff(input logic [HSW_W-1:0] w);
        return (w == '0) ? HSW_W'(1) : w;
    endfunction

    function automatic logic [VSW_W-1:0] v_width_eff(input logic [VSW_W-1:0] w);
        return (w == '0) ? VSW_W'(1) : w;
    endfunction

endpackage

// File: rtl/crtc_regfile.sv
module crtc_regfile
    import crtc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [REG_W-1:0]   wr_data,
    input  logic               frame_wrap,
    output crtc_timing_t       timing,
    output crtc_blank_t        blank
);

    crtc_timing_t shadow;
    logic         unused_hi_bits;

    assign unused_hi_bits = ^wr_data[REG_W-1:UPPER_LSB+VD_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow <= TIMING_RST;
            blank  <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                ADR_HTIME: begin
                    shadow.h_total_m1 <= wr_data[HT_W-1:0];
                    shadow.h_disp_m1  <= wr_data[UPPER_LSB +: HD_W];
                end
                ADR_HSYNC: begin
                    shadow.hs_start <= wr_data[HSS_W-1:0];
                    shadow.hs_wid   <= wr_data[UPPER_LSB +: HSW_W];
                    shadow.hs_low   <= wr_data[POL_BIT];
                end
                ADR_VTIME: begin
                    shadow.v_total_m1 <= wr_data[VT_W-1:0];
                    shadow.v_disp_m1  <= wr_data[UPPER_LSB +: VD_W];
                end
                ADR_VSYNC: begin
                    shadow.vs_start_m1 <= wr_data[VSS_W-1:0];
                    shadow.vs_wid      <= wr_data[UPPER_LSB +: VSW_W];
                    shadow.vs_low      <= wr_data[POL_BIT];
                end
                ADR_BLANK: begin
                    blank.kill_de <= wr_data[0];
                    blank.kill_hs <= wr_data[1];
                    blank.kill_vs <= wr_data[2];
                end
                default: ;
            endcase
        end
    end

    // working set follows the shadow only at a frame boundary
    always_ff @(posedge clk) begin
        if (rst)
            timing <= TIMING_RST;
        else if (frame_wrap)
            timing <= shadow;
    end

    // R9: working timing never moves except on a frame wrap
    assert_timing_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !$past(frame_wrap) |-> $stable(timing));

endmodule

// File: rtl/crtc_axis_ctr.sv
module crtc_axis_ctr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    input  logic [W-1:0] last_val,
    output logic [W-1:0] cnt,
    output logic         at_last
);

    assign at_last = (cnt >= last_val);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (step)
            cnt <= at_last ? '0 : cnt + 1'b1;
    end

    // R2: a stepping counter below its limit advances by exactly one
    assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
        (step && !at_last) |=> (cnt == $past(cnt) + 1'b1));

    // R3: without a step the position holds
    assert_count_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(cnt));

endmodule

// File: rtl/crtc_timing_gen.sv
module crtc_timing_gen
    import crtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [31:0]       wr_data,
    output logic [12:0]       pix_x,
    output logic [15:0]       line_y,
    output logic              de,
    output logic              hsync,
    output logic              vsync
);

    crtc_timing_t tm;
    crtc_blank_t  bk;
    logic         h_at_last;
    logic         v_at_last;
    logic         frame_wrap;

    logic [X_W-1:0] h_last;
    logic [X_W-1:0] h_act_last;
    logic [X_W:0]   hs_beg;
    logic [X_W:0]   hs_end;
    logic [Y_W:0]   vs_beg;
    logic [Y_W:0]   vs_end;
    logic           in_h_act;
    logic           in_v_act;
    logic           hs_pulse;
    logic           vs_pulse;

    assign frame_wrap = h_at_last && v_at_last;

    crtc_regfile u_regs (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .frame_wrap (frame_wrap),
        .timing     (tm),
        .blank      (bk)
    );

    // line length in pixels minus one: character count times eight, plus seven
    assign h_last     = {tm.h_total_m1, {CHAR_SH{1'b1}}};
    assign h_act_last = X_W'({tm.h_disp_m1, {CHAR_SH{1'b1}}});

    crtc_axis_ctr #(.W(X_W)) u_hctr (
        .clk      (clk),
        .rst      (rst),
        .step     (1'b1),
        .last_val (h_last),
        .cnt      (pix_x),
        .at_last  (h_at_last)
    );

    crtc_axis_ctr #(.W(Y_W)) u_vctr (
        .clk      (clk),
        .rst      (rst),
        .step     (h_at_last),
        .last_val (tm.v_total_m1),
        .cnt      (line_y),
        .at_last  (v_at_last)
    );

    // horizontal sync window, pixel-granular start, character-granular width
    assign hs_beg = (X_W+1)'(tm.hs_start);
    assign hs_end = hs_beg + (X_W+1)'({h_width_eff(tm.hs_wid), {CHAR_SH{1'b0}}});

    // vertical sync window, start stored minus one
    assign vs_beg = (Y_W+1)'(tm.vs_start_m1) + 1'b1;
    assign vs_end = vs_beg + (Y_W+1)'(v_width_eff(tm.vs_wid));

    assign in_h_act = (pix_x <= h_act_last);
    assign in_v_act = (line_y <= Y_W'(tm.v_disp_m1));
    assign hs_pulse = ({1'b0, pix_x} >= hs_beg) && ({1'b0, pix_x} < hs_end);
    assign vs_pulse = ({1'b0, line_y} >= vs_beg) && ({1'b0, line_y} < vs_end);

    assign de    = !bk.kill_de && in_h_act && in_v_act;
    assign hsync = (hs_pulse && !bk.kill_hs) ^ tm.hs_low;
    assign vsync = (vs_pulse && !bk.kill_vs) ^ tm.vs_low;

    // R3: the edge after the last pixel of the last line starts a frame at (0,0)
    assert_frame_restart_R3: assert property (@(posedge clk) disable iff (rst)
        frame_wrap |=> (pix_x == '0) && (line_y == '0));

    // R2: the line counter only moves on a horizontal wrap
    assert_line_moves_on_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        (line_y != $past(line_y)) |-> $past(h_at_last));

endmodule

// File: tb/crtc_timing_gen_bench.sv
module crtc_timing_gen_bench;

    localparam int CLK_PERIOD = 10;

    // timing vectors: {addr0, addr1, addr2, addr3}
    localparam logic [31:0] VEC [0:2][0:3] = '{
        '{32'h0001_0003, 32'h0001_0012, 32'h0005_0009, 32'h0002_0006},
        // zero widths (R7) and active-low syncs (R8)
        '{32'h0003_0005, 32'h0080_0023, 32'h0008_000C, 32'h0080_0009},
        '{32'h0004_0007, 32'h0002_002C, 32'h000B_000F, 32'h0083_000C}
    };
    localparam logic [31:0] DEF [0:3] = '{32'h0001_0003, 32'h0001_0014,
                                           32'h0005_0009, 32'h0001_0006};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [12:0] pix_x;
    logic [15:0] line_y;
    logic        de, hsync, vsync;

    int checks = 0;
    int bad = 0;
    bit done = 0;

    int ht, hd, hss, hsw, hsp, vt, vd, vsf, vsw, vsp, bl;

    always #(CLK_PERIOD/2) clk = ~clk;

    crtc_timing_gen u_crtc_timing_gen (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .pix_x   (pix_x),
        .line_y  (line_y),
        .de      (de),
        .hsync   (hsync),
        .vsync   (vsync)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_expect(input logic [31:0] w0, input logic [31:0] w1,
                              input logic [31:0] w2, input logic [31:0] w3);
        ht  = int'(w0[9:0]);   hd  = int'(w0[24:16]);
        hss = int'(w1[12:0]);  hsw = int'(w1[21:16]); hsp = int'(w1[23]);
        vt  = int'(w2[15:0]);  vd  = int'(w2[27:16]);
        vsf = int'(w3[11:0]);  vsw = int'(w3[20:16]); vsp = int'(w3[23]);
    endtask

    function automatic logic [2:0] model(input int x, input int y);
        int  hw;
        int  vw;
        logic e, h, v;
        hw = (hsw == 0) ? 1 : hsw;
        vw = (vsw == 0) ? 1 : vsw;
        e = (bl[0] == 0) && (x < (hd + 1) * 8) && (y <= vd);
        h = ((x >= hss) && (x < hss + 8 * hw) && (bl[1] == 0)) ^ hsp[0];
        v = ((y >= vsf + 1) && (y < vsf + 1 + vw) && (bl[2] == 0)) ^ vsp[0];
        return {e, h, v};
    endfunction

    // called at a falling edge; returns at the falling edge after the write edge
    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load_vec(input logic [31:0] w0, input logic [31:0] w1,
                            input logic [31:0] w2, input logic [31:0] w3);
        wr(3'd0, w0); wr(3'd1, w1); wr(3'd2, w2); wr(3'd3, w3);
        set_expect(w0, w1, w2, w3);
        @(negedge clk);
    endtask

    task automatic scan_frame(input string note);
        int guard;
        int n;
        int ex, ey;
        int e_cnt, e_de, e_hs, e_vs;
        int a_cnt, x_cnt, a_de, x_de, a_hs, x_hs, a_vs, x_vs;
        logic [2:0] m;
        guard = 0;
        while (!(pix_x == 0 && line_y == 0) && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        n = (ht + 1) * 8 * (vt + 1);
        ex = 0; ey = 0;
        e_cnt = 0; e_de = 0; e_hs = 0; e_vs = 0;
        a_cnt = 0; x_cnt = 0; a_de = 0; x_de = 0; a_hs = 0; x_hs = 0; a_vs = 0; x_vs = 0;
        for (int i = 0; i < n; i++) begin
            m = model(ex, ey);
            if ((int'(pix_x) != ex || int'(line_y) != ey) && e_cnt == 0) begin
                a_cnt = int'(pix_x) * 65536 + int'(line_y); x_cnt = ex * 65536 + ey;
            end
            if (int'(pix_x) != ex || int'(line_y) != ey) e_cnt++;
            if (de != m[2]) begin
                if (e_de == 0) begin a_de = int'(de); x_de = int'(m[2]); end
                e_de++;
            end
            if (hsync != m[1]) begin
                if (e_hs == 0) begin a_hs = int'(hsync); x_hs = int'(m[1]); end
                e_hs++;
            end
            if (vsync != m[0]) begin
                if (e_vs == 0) begin a_vs = int'(vsync); x_vs = int'(m[0]); end
                e_vs++;
            end
            if (ex == (ht + 1) * 8 - 1) begin
                ex = 0;
                ey = (ey == vt) ? 0 : ey + 1;
            end else begin
                ex++;
            end
            @(negedge clk);
        end
        chk(e_cnt == 0, {"R2/R3 coordinates (x*65536+y) ", note}, a_cnt, x_cnt);
        chk(e_de == 0, {"R4 de ", note}, a_de, x_de);
        chk(e_hs == 0, {"R5 hsync ", note}, a_hs, x_hs);
        chk(e_vs == 0, {"R6 vsync ", note}, a_vs, x_vs);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        int maxx;
        int maxy;
        int guard;
        bl = 0;
        set_expect(DEF[0], DEF[1], DEF[2], DEF[3]);
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(pix_x == 0 && line_y == 0, "R1 counters in reset", pix_x, 0);
        chk(de == 1'b1 && hsync == 1'b0 && vsync == 1'b0, "R1 outputs in reset",
            {de, hsync, vsync}, 3'b100);
        rst = 1'b0;
        // R1: default timing frame
        scan_frame("R1 default");

        // table of vectors
        for (int v = 0; v < 3; v++) begin
            load_vec(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3]);
            scan_frame($sformatf("vector %0d (R7 R8 on vector 1)", v));
        end

        // R9: mid-frame write leaves the current frame alone
        load_vec(VEC[0][0], VEC[0][1], VEC[0][2], VEC[0][3]);
        scan_frame("R9 setup");
        load_vec(VEC[2][0], VEC[2][1], VEC[2][2], VEC[2][3]);
        maxx = 0; maxy = 0; guard = 0;
        while (!(pix_x == 31 && line_y == 9) && guard < 2000) begin
            if (int'(pix_x) > maxx) maxx = int'(pix_x);
            if (int'(line_y) > maxy) maxy = int'(line_y);
            @(negedge clk);
            guard++;
        end
        chk(maxx <= 31 && maxy <= 9 && guard < 2000, "R9 old frame kept x limit", maxx, 31);
        @(negedge clk);
        chk(pix_x == 0 && line_y == 0, "R9 new frame start", pix_x, 0);
        scan_frame("R9 new timing");

        // R10: blanking acts on the next cycle
        load_vec(VEC[1][0], VEC[1][1], VEC[1][2], VEC[1][3]);
        scan_frame("R10 setup");
        chk(de == 1'b1, "R10 de high before blank", de, 1);
        wr(3'd4, 32'h1);
        chk(de == 1'b0, "R10 de forced low next cycle", de, 0);
        bl = 1;
        scan_frame("R10 display off");
        wr(3'd4, 32'h7);
        bl = 7;
        scan_frame("R10 all off (R8 idle high)");
        wr(3'd4, 32'h0);
        bl = 0;
        scan_frame("R10 restored");

        done = 1;
        $display("  test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end

endmodule